// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End

This block is the slave-side front end of a byte-wide memory peripheral attached to a 68xx-style multiplexed bus. It works on an address strobe, a data strobe E, a read/write select, an active-high chip enable, eight shared address/data lines and seven dedicated high address lines. All bus inputs are brought into the local clock domain through a double-flop synchroniser. Strobe edges are then found by comparing successive synchronised samples. The local clock must run several times faster than the bus.

While the address strobe is high, the low byte on the shared lines and the high bits on the dedicated lines pass into a 15-bit address register. This covers 32K bytes. When the strobe falls, the address freezes and the shared lines then carry data. In a write cycle, the byte on the shared lines is taken when E falls. It goes to the storage back end as a one-clock write request, together with the frozen address. In a read cycle, a one-clock read request goes out when E rises. The back end returns the byte one clock later. The block registers that byte and drives it onto the shared lines through an output enable until E falls.

Top module: `mux_bus_front`

## Requirements
- R1: After a synchronous reset, `wr_req`, `rd_req` and `ad_oe` are low.
- R2: The address used by a cycle is {`hi_addr`, `ad_in`} as last sampled while `as_i` was high. Changes on those lines after `as_i` has fallen do not alter it.
- R3: A write cycle is `cs_i` high and `rw_i` low at the falling edge of `e_i`. It produces exactly one `wr_req` pulse, one clock long, within 4 clocks of that edge. The pulse carries the latched address on `wr_addr` and, on `wr_data`, the byte present on `ad_in` at the edge.
- R4: A read cycle is `cs_i` high and `rw_i` high at the rising edge of `e_i`. It produces exactly one `rd_req` pulse, one clock long, with the latched address on `rd_addr`.
- R5: The back end presents `rd_data` in the clock after `rd_req`. `ad_out` then holds that byte and `ad_oe` is high while `e_i` stays high.
- R6: `ad_oe` goes low within 4 clocks after `e_i` falls.
- R7: `ad_oe` stays low throughout a write cycle.
- R8: With `cs_i` low, E edges produce no `wr_req` and no `rd_req`, and `ad_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, faster than the bus |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Address strobe; the address passes while high and is held from its fall |
| e_i | input | 1 | Data strobe E |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs_i | input | 1 | Active-high chip enable |
| ad_in | input | 8 | Shared lines as seen from the pad (low address, then write data) |
| hi_addr | input | 7 | Address bits 14 to 8 |
| ad_out | output | 8 | Read byte for the shared lines |
| ad_oe | output | 1 | Tri-state enable for the shared lines |
| wr_req | output | 1 | One-clock write request to the back end |
| wr_addr | output | 15 | Write address |
| wr_data | output | 8 | Write byte |
| rd_req | output | 1 | One-clock read request to the back end |
| rd_addr | output | 15 | Read address |
| rd_data | input | 8 | Back-end read byte, valid the clock after `rd_req` |

## Verification
A wrong address register shows up on `wr_addr` or `rd_addr` in the first request after the strobe falls. This is about four clocks after the E edge. A read then also returns the byte stored at the wrong location. If the edge detector misfires, requests are duplicated or missing, which the bench sees by counting pulses on each cycle. If the output-enable state is stuck, `ad_oe` is high during a write or stays high more than four clocks after E falls.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  // Default bus geometry: 8 shared lines plus 7 dedicated high address lines.
  localparam int DEF_DW   = 8;
  localparam int DEF_HI_W = 7;
  localparam int DEF_SYNC = 2;

  // Synchronised control strobes, kept together so their sampling delays match.
  typedef struct packed {
    logic as_s;
    logic e_s;
    logic rw_s;
    logic cs_s;
  } bus_ctl_t;

  localparam int CTL_W = $bits(bus_ctl_t);
endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbf_addr_latch.sv
module mbf_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 7,
  localparam int AW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_s,
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  output logic [AW-1:0]   addr
);
  // Follows the lines while the strobe is high, holds the last value once it falls.
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (as_s) addr <= {hi, lo};
  end

  // R2: with the strobe low, the held address may not move
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !as_s |=> $stable(addr));
endmodule

// File: rtl/mbf_cycle_ctrl.sv
module mbf_cycle_ctrl
  import mbf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_ctl_t      ctl,
  input  logic [DW-1:0] ad_s,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  bus_ctl_t ctl_q;
  logic     rd_pend;
  logic     e_rise, e_fall;

  assign e_rise = ctl.e_s & ~ctl_q.e_s;
  assign e_fall = ~ctl.e_s & ctl_q.e_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      rd_pend <= 1'b0;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_addr <= '0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
    end else begin
      ctl_q   <= ctl;
      rd_pend <= rd_req;
      wr_req  <= 1'b0;
      rd_req  <= 1'b0;
      if (e_fall && ctl.cs_s && !ctl.rw_s) begin
        wr_req  <= 1'b1;
        wr_addr <= addr;
        wr_data <= ad_s;
      end
      if (e_rise && ctl.cs_s && ctl.rw_s) begin
        rd_req  <= 1'b1;
        rd_addr <= addr;
      end
      if (!ctl.e_s || !ctl.cs_s || !ctl.rw_s) begin
        ad_oe <= 1'b0;
      end else if (rd_pend) begin
        ad_oe  <= 1'b1;
        ad_out <= rd_data;
      end
    end
  end

  // R3: write request is a single-clock pulse
  a_r3_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);
  // R4: read request is a single-clock pulse
  a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R6: the shared lines are driven only while E was seen high
  a_r6_oe_in_e: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> ctl_q.e_s);
  // R8: no request is issued without chip enable
  a_r8_req_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (wr_req || rd_req) |-> ctl_q.cs_s);
  // R3 and R4 are never decoded together
  a_r4_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_req, rd_req}));
endmodule

// File: rtl/mux_bus_front.sv
module mux_bus_front
  import mbf_pkg::*;
#(
  parameter int DW     = DEF_DW,
  parameter int HI_W   = DEF_HI_W,
  parameter int STAGES = DEF_SYNC,
  localparam int AW    = DW + HI_W,
  localparam int SW    = CTL_W + DW + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_i,
  input  logic            e_i,
  input  logic            rw_i,
  input  logic            cs_i,
  input  logic [DW-1:0]   ad_in,
  input  logic [HI_W-1:0] hi_addr,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data
);
  logic [SW-1:0]   sync_q;
  bus_ctl_t        ctl;
  logic [DW-1:0]   ad_s;
  logic [HI_W-1:0] hi_s;
  logic [AW-1:0]   addr;

  // One synchroniser for every bus input keeps their relative timing intact.
  mbf_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({as_i, e_i, rw_i, cs_i, ad_in, hi_addr}),
    .q   (sync_q)
  );

  assign ctl  = bus_ctl_t'(sync_q[SW-1 -: CTL_W]);
  assign ad_s = sync_q[HI_W +: DW];
  assign hi_s = sync_q[HI_W-1:0];

  mbf_addr_latch #(.LO_W(DW), .HI_W(HI_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .as_s (ctl.as_s),
    .lo   (ad_s),
    .hi   (hi_s),
    .addr (addr)
  );

  mbf_cycle_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .ad_s    (ad_s),
    .addr    (addr),
    .rd_data (rd_data),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe)
  );
endmodule

// File: tb/sim_mux_bus_front.sv
`timescale 1ns/1ps
module sim_mux_bus_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_i = 1'b0, e_i = 1'b0, rw_i = 1'b1, cs_i = 1'b0;
  logic [7:0]  ad_in = '0;
  logic [6:0]  hi_addr = '0;
  logic [7:0]  ad_out, wr_data, rd_data;
  logic [14:0] wr_addr, rd_addr;
  logic        ad_oe, wr_req, rd_req;

  always #4 clk = ~clk;

  mux_bus_front u0 (
    .clk(clk), .rst(rst), .as_i(as_i), .e_i(e_i), .rw_i(rw_i), .cs_i(cs_i),
    .ad_in(ad_in), .hi_addr(hi_addr), .ad_out(ad_out), .ad_oe(ad_oe),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Back-end storage model: write on request, read with one clock latency.
  logic [7:0] bmem [int];
  always @(posedge clk) begin
    if (wr_req) bmem[int'(wr_addr)] = wr_data;
    if (rd_req) rd_data <= bmem.exists(int'(rd_addr)) ? bmem[int'(rd_addr)] : 8'h00;
  end

  // Port observers.
  int         wr_cnt = 0, rd_cnt = 0;
  logic [14:0] last_wa, last_ra;
  logic [7:0]  last_wd;
  logic        oe_seen = 1'b0;
  always @(posedge clk) begin
    if (wr_req) begin wr_cnt <= wr_cnt + 1; last_wa <= wr_addr; last_wd <= wr_data; end
    if (rd_req) begin rd_cnt <= rd_cnt + 1; last_ra <= rd_addr; end
    if (ad_oe) oe_seen <= 1'b1;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic       mid_oe, end_oe;
  logic [7:0] mid_dat;

  // One bus cycle. pre_addr is shown first while the strobe is high, then addr;
  // late_hi is put on the high lines after the strobe falls.
  task automatic bus_cycle(input logic rw, input logic cs, input logic [14:0] pre_addr,
                           input logic [14:0] addr, input logic [7:0] wdata,
                           input logic [6:0] late_hi);
    @(negedge clk);
    oe_seen = 1'b0;
    rw_i = rw; cs_i = cs; as_i = 1'b1;
    hi_addr = pre_addr[14:8]; ad_in = pre_addr[7:0];
    wait_clk(3);
    hi_addr = addr[14:8]; ad_in = addr[7:0];
    wait_clk(4);
    as_i = 1'b0;
    wait_clk(4);
    hi_addr = late_hi;
    ad_in = rw ? 8'h5E : wdata;
    wait_clk(3);
    e_i = 1'b1;
    wait_clk(8);
    mid_oe = ad_oe; mid_dat = ad_out;
    e_i = 1'b0;
    wait_clk(4);
    end_oe = ad_oe;
    wait_clk(3);
    cs_i = 1'b0; rw_i = 1'b1;
    wait_clk(2);
  endtask

  // Vectors: [24] 1=read 0=write, [23:9] address, [7:0] data / expected data.
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 15'h0000, 1'b0, 8'h3C}, {1'b0, 15'h7FFF, 1'b0, 8'hC3},
    {1'b0, 15'h1234, 1'b0, 8'h5A}, {1'b0, 15'h00FF, 1'b0, 8'h01},
    {1'b0, 15'h7F00, 1'b0, 8'hFE}, {1'b1, 15'h0000, 1'b0, 8'h3C},
    {1'b1, 15'h7FFF, 1'b0, 8'hC3}, {1'b1, 15'h1234, 1'b0, 8'h5A},
    {1'b1, 15'h00FF, 1'b0, 8'h01}, {1'b1, 15'h7F00, 1'b0, 8'hFE},
    {1'b0, 15'h1234, 1'b0, 8'hA5}, {1'b1, 15'h1234, 1'b0, 8'hA5}
  };

  initial begin
    int wc0, rc0;
    wait_clk(4);
    chk("R1 wr_req", wr_req, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 ad_oe", ad_oe, 0);
    rst = 1'b0;
    wait_clk(3);

    for (int i = 0; i < 12; i++) begin
      logic [14:0] a;
      logic [7:0]  d;
      a = VEC[i][23:9]; d = VEC[i][7:0];
      wc0 = wr_cnt; rc0 = rd_cnt;
      bus_cycle(VEC[i][24], 1'b1, a, a, d, ~a[14:8]);
      if (!VEC[i][24]) begin
        chk("R3 one write request", wr_cnt - wc0, 1);
        chk("R3 write address", last_wa, a);
        chk("R3 write data", last_wd, d);
        chk("R7 no drive in write", oe_seen, 0);
        chk("R4 no read request in write", rd_cnt - rc0, 0);
      end else begin
        chk("R4 one read request", rd_cnt - rc0, 1);
        chk("R4 read address", last_ra, a);
        chk("R5 output enable", mid_oe, 1);
        chk("R5 read data", mid_dat, d);
        chk("R6 release after E", end_oe, 0);
        chk("R3 no write request in read", wr_cnt - wc0, 0);
      end
    end

    // R2: address changes during strobe high follow; changes after its fall are ignored.
    wc0 = wr_cnt;
    bus_cycle(1'b0, 1'b1, 15'h2222, 15'h4567, 8'h99, 7'h11);
    chk("R2 write count", wr_cnt - wc0, 1);
    chk("R2 latched address", last_wa, 15'h4567);
    rc0 = rd_cnt;
    bus_cycle(1'b1, 1'b1, 15'h0101, 15'h4567, 8'h00, 7'h7F);
    chk("R2 read address", last_ra, 15'h4567);
    chk("R2 read data", mid_dat, 8'h99);

    // R8: chip enable low suppresses everything.
    wc0 = wr_cnt; rc0 = rd_cnt;
    bus_cycle(1'b0, 1'b0, 15'h4567, 15'h4567, 8'h00, 7'h45);
    chk("R8 no write request", wr_cnt - wc0, 0);
    chk("R8 no drive", oe_seen, 0);
    bus_cycle(1'b1, 1'b0, 15'h4567, 15'h4567, 8'h00, 7'h45);
    chk("R8 no read request", rd_cnt - rc0, 0);
    chk("R8 no drive on read", oe_seen, 0);
    // The suppressed write must not have touched storage.
    bus_cycle(1'b1, 1'b1, 15'h4567, 15'h4567, 8'h00, 7'h45);
    chk("R8 storage unchanged", mid_dat, 8'h99);

    // R1: reset in the middle of a read drops the drive.
    @(negedge clk);
    rw_i = 1'b1; cs_i = 1'b1; as_i = 1'b0; e_i = 1'b1;
    wait_clk(8);
    rst = 1'b1;
    wait_clk(1);
    chk("R1 drive cleared by reset", ad_oe, 0);
    e_i = 1'b0; rst = 1'b0;
    wait_clk(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule